// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block is a short queue of pending processor stores, kept as address/data pairs, placed between a processor and its first-level data cache. Every store is placed here instead of going straight to the cache, so the processor can move on at once while a drain agent on the cache side takes entries out one at a time, oldest first.

Loads also consult the queue. A purely combinational lookup port takes a load address and compares it, at word granularity, with every live entry. If one or more entries hold the same word, it returns a hit together with the data of the most recently accepted of them. On a hit the requester uses the forwarded word and discards whatever the cache returned. The queue holds off new stores by dropping its ready output when every slot is in use. A store may still enter in a cycle where the full queue is also giving up its oldest entry.

Top module: `stbuf_top`

## Requirements
- R1: After a cycle with `rst_n` low, the queue is empty: `deq_valid` is 0, `enq_ready` is 1 and `srch_hit` is 0 for every search address.
- R2: With all DEPTH slots in use and `deq_pop` low, `enq_ready` is 0 and an offered store is not taken.
- R3: A search hits when a live entry holds the same word as `srch_addr`. Bits [31:2] are compared and bits [1:0] of both addresses are ignored.
- R4: When several live entries match, `srch_data` is the data of the youngest of them. This holds whatever the positions of the read and write pointers in the ring, including after they wrap.
- R5: Entries leave in the order they were accepted. While `deq_valid` is 1, `deq_addr`/`deq_data` show the oldest entry and stay stable until `deq_pop` removes it.
- R6: A store accepted in a cycle is not seen by that same cycle's search. It becomes searchable from the next cycle on.
- R7: With the queue full, a store offered with `deq_pop` high is accepted in the same cycle. The queue remains full and the new store becomes the youngest entry.
- R8: An entry that is being removed in a cycle can still be found by that cycle's search.
- R9: On a search miss, `srch_hit` is 0 and `srch_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | A store is offered |
| enq_addr | input | 32 | Byte address of the offered store |
| enq_data | input | 32 | Data word of the offered store |
| enq_ready | output | 1 | The queue can take a store this cycle |
| deq_pop | input | 1 | Drain side removes the oldest entry |
| deq_valid | output | 1 | The queue holds at least one entry |
| deq_addr | output | 32 | Address of the oldest entry |
| deq_data | output | 32 | Data of the oldest entry |
| srch_addr | input | 32 | Load address to look up |
| srch_hit | output | 1 | A live entry holds the same word |
| srch_data | output | 32 | Data of the youngest matching entry, zero on a miss |

## Verification
The hardest case to reach is a youngest-match choice among duplicate words when the youngest copy sits at a lower slot than an older copy, after the write pointer has wrapped past the end of the ring. Store addresses are drawn from a pool of only six words with random low bits, so duplicate words are common. Random pops keep the pointers moving around the ring. A directed sequence also fills the queue with repeated words, swaps an entry in while full and then stores a word again after the wrap, so this case occurs at known cycles.

// File: rtl/stbuf_pkg.sv
// Shared widths and the entry record of the store buffer.
// Assumes 32-bit byte addresses and 32-bit data words.
package stbuf_pkg;
    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 32;
    localparam int ALIGN_LSB = 2;   // low address bits that pick a byte inside a word

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } stbuf_entry_t;
endpackage

// File: rtl/stbuf_ctrl.sv
// Ring pointer and occupancy control of the store buffer.
// Decides which handshakes fire each cycle. A pop frees a slot before the same
// cycle's push is judged, so a full ring can push and pop together.
// Assumes DEPTH >= 2.
module stbuf_ctrl #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic             deq_pop,
    output logic             enq_ready,
    output logic             deq_valid,
    output logic             enq_fire,
    output logic             deq_fire,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    // Advances a ring pointer by one slot with wrap.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Handshake decisions for this cycle.
    always_comb begin
        deq_valid = (count != '0);
        deq_fire  = deq_valid && deq_pop;
        enq_ready = (count != FULL_CNT) || deq_fire;
        enq_fire  = enq_valid && enq_ready;
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (deq_fire) head <= bump(head);
            if (enq_fire) tail <= bump(tail);
            case ({enq_fire, deq_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Occupancy follows the accepted pushes and pops of the previous cycle.
    assert_count_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) + CNT_W'($past(enq_fire)) - CNT_W'($past(deq_fire))));

    // A full ring with no pop must refuse a store.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && !deq_pop) |-> !enq_ready);

    // Occupancy never exceeds the ring size.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
endmodule

// File: rtl/stbuf_search.sv
// Youngest-match lookup over the live entries of the store buffer.
// Slots are visited by age, from the oldest (head) to the youngest. A later
// match replaces an earlier one, so the result is correct across pointer wrap.
// Assumes entries outside the live range are never reported.
module stbuf_search
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  stbuf_entry_t [DEPTH-1:0] ents,
    input  logic [PTR_W-1:0]         head,
    input  logic [CNT_W-1:0]         count,
    input  logic [ADDR_W-1:0]        srch_addr,
    output logic                     srch_hit,
    output logic [WORD_W-1:0]        srch_data
);
    logic [DEPTH-1:0]             age_match;
    logic [DEPTH-1:0][WORD_W-1:0] age_data;

    // One comparator per age position, mapped onto a ring slot.
    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [PTR_W:0]   sum;
        logic [PTR_W-1:0] slot;
        always_comb begin
            sum  = {1'b0, head} + (PTR_W + 1)'(k);
            if (sum >= (PTR_W + 1)'(DEPTH)) sum = sum - (PTR_W + 1)'(DEPTH);
            slot = sum[PTR_W-1:0];
        end
        assign age_match[k] = (CNT_W'(k) < count) &&
            (ents[slot].addr[ADDR_W-1:ALIGN_LSB] == srch_addr[ADDR_W-1:ALIGN_LSB]);
        assign age_data[k]  = ents[slot].data;
    end

    // Priority pick: the highest age index that matches wins.
    always_comb begin
        srch_hit  = 1'b0;
        srch_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (age_match[k]) begin
                srch_hit  = 1'b1;
                srch_data = age_data[k];
            end
        end
    end

    // An empty ring can never produce a hit.
    assert_hit_needs_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !srch_hit);

    // A miss drives a zero word.
    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_hit |-> (srch_data == '0));
endmodule

// File: rtl/stbuf_top.sv
// Store buffer: a ring of address/data pairs with oldest-first draining and
// a combinational youngest-match search for load forwarding.
// Assumes the drain side pops only while deq_valid is high (extra pops are ignored).
module stbuf_top
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [WORD_W-1:0] enq_data,
    output logic              enq_ready,
    input  logic              deq_pop,
    output logic              deq_valid,
    output logic [ADDR_W-1:0] deq_addr,
    output logic [WORD_W-1:0] deq_data,
    input  logic [ADDR_W-1:0] srch_addr,
    output logic              srch_hit,
    output logic [WORD_W-1:0] srch_data
);
    stbuf_entry_t [DEPTH-1:0] ents;
    logic                     enq_fire;
    logic                     deq_fire;
    logic [PTR_W-1:0]         head;
    logic [PTR_W-1:0]         tail;
    logic [CNT_W-1:0]         count;

    stbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .deq_pop   (deq_pop),
        .enq_ready (enq_ready),
        .deq_valid (deq_valid),
        .enq_fire  (enq_fire),
        .deq_fire  (deq_fire),
        .head      (head),
        .tail      (tail),
        .count     (count)
    );

    // Entry storage: the accepted store is written at the tail slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents <= '0;
        end else if (enq_fire) begin
            ents[tail] <= '{addr: enq_addr, data: enq_data};
        end
    end

    // Oldest entry presented to the drain side.
    always_comb begin
        deq_addr = ents[head].addr;
        deq_data = ents[head].data;
    end

    stbuf_search #(.DEPTH(DEPTH)) search_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ents      (ents),
        .head      (head),
        .count     (count),
        .srch_addr (srch_addr),
        .srch_hit  (srch_hit),
        .srch_data (srch_data)
    );

    // A head that is not popped stays in place with the same contents.
    assert_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !deq_pop) |=> (deq_valid && $stable(deq_addr) && $stable(deq_data)));

    // A store accepted into an empty ring becomes the visible head next cycle.
    assert_first_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!deq_valid && enq_fire) |=> (deq_valid && deq_addr == $past(enq_addr)));
endmodule

// File: tb/stbuf_top_tb_top.sv
// Bench for the store buffer: a queue model ordered by age, directed corner
// sequences, then seeded random traffic over a small address pool.
module stbuf_top_tb_top;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic [31:0] enq_addr = '0;
    logic [31:0] enq_data = '0;
    logic        enq_ready;
    logic        deq_pop = 1'b0;
    logic        deq_valid;
    logic [31:0] deq_addr;
    logic [31:0] deq_data;
    logic [31:0] srch_addr = '0;
    logic        srch_hit;
    logic [31:0] srch_data;

    int vectors = 0;
    int fails = 0;

    logic [31:0] m_a [DEPTH];
    logic [31:0] m_d [DEPTH];
    int          m_n = 0;

    logic        obs_hit, obs_rdy, obs_dv;
    logic [31:0] obs_sdata, obs_daddr, obs_ddata;

    always #5 clk = ~clk;

    stbuf_top #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_data(enq_data), .enq_ready(enq_ready),
        .deq_pop(deq_pop), .deq_valid(deq_valid), .deq_addr(deq_addr), .deq_data(deq_data),
        .srch_addr(srch_addr), .srch_hit(srch_hit), .srch_data(srch_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Youngest word match in the model (index 0 is the oldest).
    function automatic logic [32:0] model_search(input logic [31:0] a);
        logic [32:0] r = '0;
        for (int i = 0; i < m_n; i++)
            if (m_a[i][31:2] == a[31:2]) r = {1'b1, m_d[i]};
        return r;
    endfunction

    // One cycle: drive, compare all outputs with the model, then advance the model.
    task automatic step(input logic ev, input logic [31:0] ea, input logic [31:0] ed,
                        input logic dp, input logic [31:0] sa);
        logic [32:0] exp_s;
        logic        exp_rdy, pop, push;
        @(negedge clk);
        enq_valid = ev; enq_addr = ea; enq_data = ed; deq_pop = dp; srch_addr = sa;
        #1;
        obs_hit = srch_hit; obs_sdata = srch_data; obs_rdy = enq_ready;
        obs_dv = deq_valid; obs_daddr = deq_addr; obs_ddata = deq_data;
        exp_s   = model_search(sa);
        pop     = dp && (m_n > 0);
        exp_rdy = (m_n < DEPTH) || pop;
        chk("R2 enq_ready", {31'd0, obs_rdy}, {31'd0, exp_rdy});
        chk("R5 deq_valid", {31'd0, obs_dv}, {31'd0, m_n > 0});
        if (m_n > 0) begin
            chk("R5 deq_addr", obs_daddr, m_a[0]);
            chk("R5 deq_data", obs_ddata, m_d[0]);
        end
        chk("R3 srch_hit", {31'd0, obs_hit}, {31'd0, exp_s[32]});
        chk("R4 srch_data", obs_sdata, exp_s[31:0]);
        push = ev && exp_rdy;
        @(posedge clk);
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                m_a[i] = m_a[i+1];
                m_d[i] = m_d[i+1];
            end
            m_n--;
        end
        if (push) begin
            m_a[m_n] = ea;
            m_d[m_n] = ed;
            m_n++;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2718);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty after reset
        chk("R1 deq_valid", {31'd0, deq_valid}, 32'd0);
        chk("R1 enq_ready", {31'd0, enq_ready}, 32'd1);
        chk("R1 srch_hit", {31'd0, srch_hit}, 32'd0);

        // R6: store accepted this cycle is invisible to this cycle's search
        step(1, 32'h100, 32'h11, 0, 32'h100);
        chk("R6 same-cycle hit", {31'd0, obs_hit}, 32'd0);
        step(1, 32'h104, 32'h22, 0, 32'h100);
        chk("R6 next-cycle hit", {31'd0, obs_hit}, 32'd1);
        step(1, 32'h103, 32'h33, 0, 32'h102);
        step(0, 32'h0, 32'h0, 0, 32'h102);
        // R3/R4: low bits ignored, youngest duplicate wins
        chk("R4 youngest dup", obs_sdata, 32'h33);
        step(1, 32'h200, 32'h44, 0, 32'h0);
        // R2: full with no pop refuses
        step(1, 32'h300, 32'h55, 0, 32'h0);
        chk("R2 full refuse", {31'd0, obs_rdy}, 32'd0);
        // R7: full with pop accepts the store
        step(1, 32'h300, 32'h55, 1, 32'h101);
        chk("R7 full swap ready", {31'd0, obs_rdy}, 32'd1);
        chk("R7 search during swap", obs_sdata, 32'h33);
        step(0, 32'h0, 32'h0, 0, 32'h301);
        chk("R7 new youngest", obs_sdata, 32'h55);
        chk("R7 still full", {31'd0, obs_rdy}, 32'd0);
        // R8: entry being popped is still found
        step(0, 32'h0, 32'h0, 1, 32'h104);
        chk("R8 popped entry hit", obs_sdata, 32'h22);
        // R9: after removal it misses with zero data
        step(0, 32'h0, 32'h0, 0, 32'h104);
        chk("R9 miss hit", {31'd0, obs_hit}, 32'd0);
        chk("R9 miss data", obs_sdata, 32'd0);
        // R4 across wrap: a younger copy now sits below an older one
        step(1, 32'h202, 32'h66, 0, 32'h0);
        step(0, 32'h0, 32'h0, 0, 32'h201);
        chk("R4 wrap youngest", obs_sdata, 32'h66);
        // drain, checking order through the model
        for (int i = 0; i < 6; i++) step(0, 32'h0, 32'h0, 1, 32'h200);

        // Seeded random traffic over six words with random low bits
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a, s;
            a = 32'h1000 + (($urandom % 6) << 2) + ($urandom % 4);
            s = 32'h1000 + (($urandom % 7) << 2) + ($urandom % 4);
            step(($urandom % 3) != 0, a, $urandom, ($urandom % 2) == 0, s);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule